// File: doc/BRIEF.md
# Four-Phase Sampling Time-to-Digital Converter

This block stamps the rising and falling edges of one or more hit inputs with a time finer than one reference clock period. Each hit line is captured by four flops, each on its own copy of the reference clock shifted by a quarter period. The samples are brought into the phase-0 domain through two register stages. The five-sample sequence made of the previous cycle's last sample and the current four samples is then searched for a change of level.

The quarter-period position of the first changed sample forms a 2-bit fine code. The fine code sits under a coarse cycle count to make the timestamp. Leading and trailing edges leave on separate lanes, each with its own one-cycle valid strobe, so pulse width is the difference of two stamps. A wrap flag marks the last cycle of each coarse period. The four clock phases come from outside the block.

Top module: `tdc_4phase`

## Requirements
- R1: While rst_n is low, every valid strobe and the wrap flag are low, and the coarse counter is cleared to 0.
- R2: The coarse counter advances by one on every phase-0 rising edge, modulo 2^CW. wrap is high exactly during the cycle in which the counter holds its all-ones value.
- R3: A hit is sampled at phases 0, 90, 180 and 270 of the reference period. The fine code is the index (0 to 3, in that phase order) of the first sample that shows the new level. A change between the previous cycle's phase-270 sample and the current phase-0 sample gives fine code 0.
- R4: A timestamp is CW+2 bits wide. The fine code occupies bits [1:0], and the coarse count sits above it, equal to the counter value during the sampling cycle.
- R5: For an edge sampled in the cycle that starts at phase-0 edge k, the strobe and timestamp are presented for exactly one cycle, starting at phase-0 edge k+3.
- R6: Rising edges are reported on the lead lane and falling edges on the trail lane. Both lanes of a channel may report in the same cycle.
- R7: When several edges of one direction fall inside one cycle, only the earliest is reported.
- R8: A pulse that begins and ends between two consecutive sampling instants produces no report.
- R9: Channels are sampled and reported independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p0 | input | 1 | Reference clock, phase 0; all outputs are in this domain |
| clk_p90 | input | 1 | Reference clock delayed by a quarter period |
| clk_p180 | input | 1 | Reference clock delayed by half a period |
| clk_p270 | input | 1 | Reference clock delayed by three quarters of a period |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | N_CH | Hit inputs, one per channel |
| lead_dv | output | N_CH | Rising-edge report strobe, per channel |
| lead_ts | output | N_CH*(CW+2) | Rising-edge timestamps, channel c at bits [c*(CW+2) +: CW+2] |
| trail_dv | output | N_CH | Falling-edge report strobe, per channel |
| trail_ts | output | N_CH*(CW+2) | Falling-edge timestamps, same packing as lead_ts |
| wrap | output | 1 | High while the coarse counter is all ones |

## Verification
An edge driven within the cycle that starts at phase-0 edge k is due on its lane after edge k+3. The exception is an edge placed after the phase-270 sample: it is caught by the next phase-0 sample, so it is due one cycle later, with fine code 0 and the next coarse value. The driver computes this due cycle, together with the expected stamp, from the offset of the edge within the cycle. The monitor compares each strobe at the falling edge of phase 0 against the head of its lane's queue, and flags any report that comes early, late or unexpected. The wrap flag is compared every cycle against a bench-kept count of phase-0 edges since reset.

// File: rtl/tdc_4phase.sv
module tdc_4phase #(
  parameter int N_CH = 2,
  parameter int CW   = 3
) (
  input  logic                     clk_p0,
  input  logic                     clk_p90,
  input  logic                     clk_p180,
  input  logic                     clk_p270,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          hit,
  output logic [N_CH-1:0]          lead_dv,
  output logic [N_CH*(CW+2)-1:0]   lead_ts,
  output logic [N_CH-1:0]          trail_dv,
  output logic [N_CH*(CW+2)-1:0]   trail_ts,
  output logic                     wrap
);
  localparam int TSW = CW + 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_p0 or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;

  assign wrap = &cnt;

  function automatic logic [2:0] first_set(input logic [3:0] v);
    logic [2:0] r;
    r = 3'b000;
    for (int i = 3; i >= 0; i--)
      if (v[i]) r = {1'b1, i[1:0]};
    return r;
  endfunction

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic          s0, s1, s2, s3;
    logic [3:0]    m1, m2;
    logic [CW-1:0] c1, c2;
    logic          last;
    logic [4:0]    seq;
    logic [3:0]    rise, fall;
    logic [2:0]    rp, fp;

    always_ff @(posedge clk_p0   or negedge rst_n) if (!rst_n) s0 <= 1'b0; else s0 <= hit[c];
    always_ff @(posedge clk_p90  or negedge rst_n) if (!rst_n) s1 <= 1'b0; else s1 <= hit[c];
    always_ff @(posedge clk_p180 or negedge rst_n) if (!rst_n) s2 <= 1'b0; else s2 <= hit[c];
    always_ff @(posedge clk_p270 or negedge rst_n) if (!rst_n) s3 <= 1'b0; else s3 <= hit[c];

    always_ff @(posedge clk_p0 or negedge rst_n)
      if (!rst_n) begin
        m1 <= '0; m2 <= '0; c1 <= '0; c2 <= '0; last <= 1'b0;
      end else begin
        m1   <= {s3, s2, s1, s0};
        c1   <= cnt;
        m2   <= m1;
        c2   <= c1;
        last <= m2[3];
      end

    assign seq  = {m2, last};
    assign rise = ~seq[3:0] &  seq[4:1];
    assign fall =  seq[3:0] & ~seq[4:1];
    assign rp   = first_set(rise);
    assign fp   = first_set(fall);

    always_ff @(posedge clk_p0 or negedge rst_n)
      if (!rst_n) begin
        lead_dv[c]  <= 1'b0;
        trail_dv[c] <= 1'b0;
        lead_ts[c*TSW +: TSW]  <= '0;
        trail_ts[c*TSW +: TSW] <= '0;
      end else begin
        lead_dv[c]  <= rp[2];
        trail_dv[c] <= fp[2];
        lead_ts[c*TSW +: TSW]  <= {c2, rp[1:0]};
        trail_ts[c*TSW +: TSW] <= {c2, fp[1:0]};
      end
  end
endmodule

// File: rtl/tdc_4phase_chk.sv
module tdc_4phase_chk #(
  parameter int N_CH = 2,
  parameter int CW   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CH-1:0]        lead_dv,
  input logic [N_CH*(CW+2)-1:0] lead_ts,
  input logic [N_CH-1:0]        trail_dv,
  input logic [N_CH*(CW+2)-1:0] trail_ts,
  input logic                   wrap
);
  localparam int TSW = CW + 2;
  logic [CW-1:0] cc;
  logic [1:0]    age;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cc <= '0; age <= '0;
    end else begin
      cc <= cc + 1'b1;
      if (age != 2'd3) age <= age + 1'b1;
    end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd3) |-> (lead_dv == '0 && trail_dv == '0));

  // R2
  wrap_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap == (&cc));

  // R2
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap);

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R5
    lead_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_dv[c] |-> lead_ts[c*TSW+2 +: CW] == CW'(cc - CW'(3)));
    // R5
    trail_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trail_dv[c] |-> trail_ts[c*TSW+2 +: CW] == CW'(cc - CW'(3)));
    // R6
    distinct_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_dv[c] && trail_dv[c]) |-> lead_ts[c*TSW +: 2] != trail_ts[c*TSW +: 2]);
  end
endmodule

bind tdc_4phase tdc_4phase_chk #(.N_CH(N_CH), .CW(CW)) u_chk (
  .clk(clk_p0), .rst_n(rst_n), .lead_dv(lead_dv), .lead_ts(lead_ts),
  .trail_dv(trail_dv), .trail_ts(trail_ts), .wrap(wrap)
);

// File: tb/tdc_4phase_tb.sv
`timescale 1ns/100ps
module tdc_4phase_tb;
  logic clk0 = 0, clk90 = 0, clk180 = 0, clk270 = 0;
  logic rst_n = 0;
  logic [1:0] hit = '0;
  logic [1:0] lead_dv, trail_dv;
  logic [9:0] lead_ts, trail_ts;
  logic wrap;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [2:0] bc = '0;
  int expq [4][$];
  string cur_req = "R3";
  int base_cyc;
  logic [2:0] base_bc;
  realtime base_t;

  initial forever #5 clk0 = ~clk0;
  initial begin #2.5; forever #5 clk90 = ~clk90; end
  initial begin #5.0; forever #5 clk180 = ~clk180; end
  initial begin #7.5; forever #5 clk270 = ~clk270; end

  tdc_4phase u_dut (
    .clk_p0(clk0), .clk_p90(clk90), .clk_p180(clk180), .clk_p270(clk270),
    .rst_n(rst_n), .hit(hit), .lead_dv(lead_dv), .lead_ts(lead_ts),
    .trail_dv(trail_dv), .trail_ts(trail_ts), .wrap(wrap)
  );

  always @(posedge clk0 or negedge rst_n)
    if (!rst_n) begin bc <= '0; cyc <= 0; end
    else begin bc <= bc + 3'd1; cyc <= cyc + 1; end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic at_edge();
    @(posedge clk0);
    #0.1;
    base_cyc = cyc; base_bc = bc; base_t = $realtime - 0.1;
  endtask

  task automatic set_hit(input int ch, input bit lvl, input real off, input bit push);
    int fine, nxt;
    logic [2:0] co;
    #(base_t + off - $realtime);
    hit[ch] = lvl;
    if (push) begin
      fine = off < 2.5 ? 1 : off < 5.0 ? 2 : off < 7.5 ? 3 : 0;
      nxt  = off > 7.5 ? 1 : 0;
      co   = base_bc + 3'(nxt);
      expq[ch*2 + (lvl ? 0 : 1)].push_back((base_cyc + 3 + nxt) * 32 + {co, fine[1:0]});
    end
  endtask

  always @(negedge clk0) if (rst_n) begin
    for (int l = 0; l < 4; l++) begin
      int ch, item;
      bit dv;
      logic [4:0] ts;
      ch = l / 2;
      dv = (l % 2 == 0) ? lead_dv[ch] : trail_dv[ch];
      ts = (l % 2 == 0) ? lead_ts[ch*5 +: 5] : trail_ts[ch*5 +: 5];
      if (dv) begin
        if (expq[l].size() == 0) check(0, cur_req, $sformatf("unexpected report lane %0d", l), int'(ts), -1);
        else begin
          item = expq[l].pop_front();
          check(item / 32 == cyc, cur_req, $sformatf("R5 due cycle lane %0d", l), cyc, item / 32);
          check(ts == 5'(item % 32), cur_req, $sformatf("R4 timestamp lane %0d", l), int'(ts), item % 32);
        end
      end else if (expq[l].size() != 0 && expq[l][0] / 32 <= cyc) begin
        item = expq[l].pop_front();
        check(0, cur_req, $sformatf("missing report lane %0d", l), cyc, item / 32);
      end
    end
    check(wrap == (bc == 3'd7), "R2", "wrap flag", int'(wrap), int'(bc == 3'd7));
  end

  initial begin
    #200000;
    check(0, "watchdog", "run timed out", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk0);
  endtask

  initial begin
    #13;
    // R1: reset state
    check(lead_dv == 0 && trail_dv == 0, "R1", "strobes in reset", int'({lead_dv, trail_dv}), 0);
    check(wrap == 0, "R1", "wrap in reset", int'(wrap), 0);
    #5 rst_n = 1;
    idle(3);

    // R3: rising edge at each quarter, falling edge later
    cur_req = "R3";
    for (int q = 0; q < 4; q++) begin
      at_edge(); set_hit(0, 1, 1.0 + 2.5 * q, 1);
      at_edge(); set_hit(0, 0, 8.5 - 2.5 * q, 1);
      idle(5);
    end

    // R6: both directions in one cycle
    cur_req = "R6";
    at_edge(); set_hit(0, 1, 1.0, 1); set_hit(0, 0, 6.0, 1);
    idle(6);

    // R7: rise, fall, rise in one cycle; earliest rise kept
    cur_req = "R7";
    at_edge(); set_hit(0, 1, 1.0, 1); set_hit(0, 0, 3.5, 1); set_hit(0, 1, 6.0, 0);
    idle(2);
    at_edge(); set_hit(0, 0, 2.0, 1);
    idle(6);

    // R8: glitch between samples is not reported
    cur_req = "R8";
    at_edge(); set_hit(0, 1, 0.5, 0); set_hit(0, 0, 2.0, 0);
    idle(6);
    check(expq[0].size() == 0 && expq[1].size() == 0, "R8", "queue after glitch", expq[0].size() + expq[1].size(), 0);

    // R9: two channels at once with different positions
    cur_req = "R9";
    at_edge(); set_hit(1, 1, 1.0, 1); set_hit(0, 1, 6.0, 1);
    at_edge(); set_hit(0, 0, 3.5, 1); set_hit(1, 0, 8.5, 1);
    idle(6);

    // R4: coarse field across a counter wrap
    cur_req = "R4";
    for (int k = 0; k < 10; k++) begin
      at_edge(); set_hit(k % 2, 1, 3.5, 1); set_hit(k % 2, 0, 8.5, 1);
    end
    idle(8);

    for (int l = 0; l < 4; l++)
      check(expq[l].size() == 0, "R5", $sformatf("leftover lane %0d", l), expq[l].size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule